// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Alarm Controller

This block sits beside the timekeeping counters of a real-time clock. It holds the eight-bit control register, three alarm bytes and three event flags. A flag is raised by the periodic-rate tick, by a one-second tick whose current seconds, minutes and hours all match the alarm bytes, and by the update-ended strobe. Any flag whose enable bit is set pulls the active-low interrupt line down.

A host reads and writes through a small register port. Reading the flag register returns the flags and a summary bit, then clears all of them. The block also gates the square-wave source onto its output pin. The rate divider and the time counters live outside the block and feed it ticks and time bytes.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: Reset (rst_ni low) clears PIE (ctrl bit 6), AIE (bit 5), UIE (bit 4), SQWE (bit 3), all flags and the alarm bytes, and releases irq_no high.
- R2: Reset leaves SET (bit 7), DM (bit 2), 24/12 (bit 1) and DSE (bit 0) at their last written values.
- R3: Address 0 is the control register, read back as written. Addresses 2, 3 and 4 hold the seconds, minutes and hours alarm bytes and read back as written. Addresses 5 to 7 read 0.
- R4: A control write that takes SET from 0 to 1 clears UIE whatever value is written to bit 4. A write while SET is already 1 stores UIE as written.
- R5: Each per_tick_i pulse sets the periodic flag whatever the value of PIE. That flag drives irq_no low only while PIE is 1.
- R6: The alarm flag is set on a sec_tick_i cycle only when all three time bytes match their alarm bytes. A mismatch in any byte, or a match without a tick, leaves it clear. It drives irq_no low only while AIE is 1.
- R7: An alarm byte whose bits 7 and 6 are both 1 matches any time byte. A byte with only one of those bits set is compared exactly.
- R8: Each upd_done_i pulse sets the update-ended flag, which drives irq_no low only while UIE is 1.
- R9: Address 1 reads {summary, PF, AF, UF, 4'b0}, with the summary bit (bit 7) equal to 1 when any enabled flag is set. The read clears all flags, and irq_no goes high in the next cycle.
- R10: sqw_o follows sqw_src_i while SQWE is 1 and is held low while SQWE is 0.
- R11: irq_no follows the flags and enables without delay: enabling a flag that is already set drives irq_no low in the cycle after the write.
- R12: A flag event in the same cycle as a flag-register read is kept for the next read. The read in progress does not show it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (a flag read clears the flags) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| time_sec_i | input | 8 | Current seconds byte |
| time_min_i | input | 8 | Current minutes byte |
| time_hr_i | input | 8 | Current hours byte |
| sec_tick_i | input | 1 | One-second tick |
| per_tick_i | input | 1 | Periodic-rate tick |
| upd_done_i | input | 1 | Update-ended strobe |
| sqw_src_i | input | 1 | Square-wave source at the selected rate |
| sqw_o | output | 1 | Gated square-wave output |
| irq_no | output | 1 | Active-low interrupt |

## Verification
On every cycle the assertions check that reset has cleared the enables and flags, that a SET rising edge leaves UIE at 0, that a periodic tick and a matching alarm tick each leave their flag set, that a flag read with no event in the same cycle releases the interrupt, and that the square-wave pin stays low while SQWE is 0. Only the bench scenarios show the rest. These cover the bits that reset keeps, the exact readback values including the summary bit, the wildcard rule against bytes with one top bit set, enable masking of each flag source, and an event arriving during a read that survives to the next read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_FLAG    = 3'd1;
  localparam logic [2:0] ADDR_ALM_SEC = 3'd2;

  localparam int CTL_SET  = 7;
  localparam int CTL_PIE  = 6;
  localparam int CTL_AIE  = 5;
  localparam int CTL_UIE  = 4;
  localparam int CTL_SQWE = 3;

  localparam int NUM_FLAGS = 3;
  // flag vector order, also the read order below the summary bit
  localparam int FLG_PF = 2;
  localparam int FLG_AF = 1;
  localparam int FLG_UF = 0;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int EN_LO = CTL_SQWE;
  localparam int EN_HI = CTL_PIE;

  logic [DATA_W-1:0] keep_q;
  logic [EN_HI:EN_LO] en_q;
  logic set_rise;

  assign set_rise = wdata_i[CTL_SET] & ~keep_q[CTL_SET];

  // SET, DM, 24/12, DSE survive reset
  always_ff @(posedge clk_i) begin
    if (wr_i) keep_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q           <= wdata_i[EN_HI:EN_LO];
      en_q[CTL_UIE]  <= wdata_i[CTL_UIE] & ~set_rise;
    end
  end

  always_comb begin
    ctrl_o              = keep_q;
    ctrl_o[EN_HI:EN_LO] = en_q;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int DATA_W = 8,
  parameter int NUM_B  = 3
) (
  input  logic [NUM_B-1:0][DATA_W-1:0] time_i,
  input  logic [NUM_B-1:0][DATA_W-1:0] alarm_i,
  output logic                         hit_o
);
  logic [NUM_B-1:0] byte_hit;

  for (genvar k = 0; k < NUM_B; k++) begin : g_byte
    logic wild;
    assign wild        = &alarm_i[k][DATA_W-1:DATA_W-2];
    assign byte_hit[k] = wild | (alarm_i[k] == time_i[k]);
  end

  assign hit_o = &byte_hit;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NUM_F = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_F-1:0] set_i,
  input  logic             clr_i,
  input  logic [NUM_F-1:0] en_i,
  output logic [NUM_F-1:0] flags_o,
  output logic             any_o
);
  logic [NUM_F-1:0] flags_q;

  for (genvar f = 0; f < NUM_F; f++) begin : g_flag
    // a new event wins over a read clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[f] <= 1'b0;
      else if (set_i[f])  flags_q[f] <= 1'b1;
      else if (clr_i)     flags_q[f] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign any_o   = |(flags_q & en_i);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] time_sec_i,
  input  logic [DATA_W-1:0] time_min_i,
  input  logic [DATA_W-1:0] time_hr_i,
  input  logic              sec_tick_i,
  input  logic              per_tick_i,
  input  logic              upd_done_i,
  input  logic              sqw_src_i,
  output logic              sqw_o,
  output logic              irq_no
);
  localparam int NUM_T = 3;
  localparam int PAD_W = DATA_W - NUM_FLAGS - 1;

  logic [DATA_W-1:0]            ctrl_q;
  logic [NUM_T-1:0][DATA_W-1:0] alm_q;
  logic [NUM_T-1:0][DATA_W-1:0] time_v;
  logic [NUM_T-1:0][DATA_W-1:0] alm_rd;
  logic [NUM_FLAGS-1:0]         flag_set, flag_en, flags_q;
  logic                         alarm_hit, irq_any, flag_rd;

  assign time_v = {time_hr_i, time_min_i, time_sec_i};

  rtc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i && reg_addr_i == ADDR_CTRL),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  for (genvar k = 0; k < NUM_T; k++) begin : g_alm
    localparam logic [ADDR_W-1:0] ADDR_K = ADDR_W'(int'(ADDR_ALM_SEC) + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              alm_q[k] <= '0;
      else if (reg_wr_i && reg_addr_i == ADDR_K) alm_q[k] <= reg_wdata_i;
    end
    assign alm_rd[k] = (reg_addr_i == ADDR_K) ? alm_q[k] : '0;
  end

  rtc_alarm_match #(.DATA_W(DATA_W), .NUM_B(NUM_T)) u_match (
    .time_i  (time_v),
    .alarm_i (alm_q),
    .hit_o   (alarm_hit)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FLG_PF] = per_tick_i;
    flag_set[FLG_AF] = sec_tick_i & alarm_hit;
    flag_set[FLG_UF] = upd_done_i;
    flag_en          = '0;
    flag_en[FLG_PF]  = ctrl_q[CTL_PIE];
    flag_en[FLG_AF]  = ctrl_q[CTL_AIE];
    flag_en[FLG_UF]  = ctrl_q[CTL_UIE];
  end

  assign flag_rd = reg_rd_i && reg_addr_i == ADDR_FLAG;

  rtc_irq_flags #(.NUM_F(NUM_FLAGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_rd),
    .en_i    (flag_en),
    .flags_o (flags_q),
    .any_o   (irq_any)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_T; k++) reg_rdata_o |= alm_rd[k];
    if (reg_addr_i == ADDR_CTRL) reg_rdata_o = ctrl_q;
    if (reg_addr_i == ADDR_FLAG) reg_rdata_o = {irq_any, flags_q, {PAD_W{1'b0}}};
  end

  assign irq_no = ~irq_any;
  assign sqw_o  = ctrl_q[CTL_SQWE] & sqw_src_i;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic                 reg_wr_i,
  input logic                 reg_rd_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic                 sec_tick_i,
  input logic                 per_tick_i,
  input logic                 upd_done_i,
  input logic                 sqw_o,
  input logic                 irq_no,
  input logic [DATA_W-1:0]    ctrl_q,
  input logic [NUM_FLAGS-1:0] flags_q,
  input logic                 alarm_hit
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1 : assert (irq_no && ctrl_q[CTL_PIE:CTL_SQWE] == '0 && flags_q == '0)
        else $error("enables or flags not cleared in reset");
    end
  end

  p_uie_clear_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[CTL_SET] && !ctrl_q[CTL_SET])
      |=> !ctrl_q[CTL_UIE]);

  p_pf_set_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_i |=> flags_q[FLG_PF]);

  p_af_set_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && alarm_hit) |=> flags_q[FLG_AF]);

  p_irq_release_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_FLAG && !per_tick_i && !sec_tick_i && !upd_done_i)
      |=> irq_no);

  p_sqw_gate_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTL_SQWE] |-> !sqw_o);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .sec_tick_i  (sec_tick_i),
  .per_tick_i  (per_tick_i),
  .upd_done_i  (upd_done_i),
  .sqw_o       (sqw_o),
  .irq_no      (irq_no),
  .ctrl_q      (ctrl_q),
  .flags_q     (flags_q),
  .alarm_hit   (alarm_hit)
);

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [2:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [7:0] time_sec_i = '0, time_min_i = '0, time_hr_i = '0;
  logic       sec_tick_i = 1'b0, per_tick_i = 1'b0, upd_done_i = 1'b0;
  logic       sqw_src_i = 1'b0;
  logic       sqw_o, irq_no;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;

  rtc_irq_ctrl u_rtc_irq_ctrl (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(); reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    step(); reg_wr_i = 1'b0;
  endtask

  // driver: push expectation, monitor compares during the read cycle
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input logic [7:0] m,
                    input string req, input bit ptick = 1'b0);
    step(); reg_addr_i = a; reg_rd_i = 1'b1; per_tick_i = ptick;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(req);
    step(); reg_rd_i = 1'b0; per_tick_i = 1'b0;
  endtask

  task automatic pulse(input int which);
    step();
    case (which)
      0: per_tick_i = 1'b1;
      1: sec_tick_i = 1'b1;
      default: upd_done_i = 1'b1;
    endcase
    step(); per_tick_i = 1'b0; sec_tick_i = 1'b0; upd_done_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    time_sec_i = s; time_min_i = m; time_hr_i = h;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk_i); #3;
      if (reg_rd_i && exp_q.size() > 0) begin
        logic [7:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        chk(t, reg_rdata_o & m, e & m);
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) step();
    sqw_src_i = 1'b1;
    chk("R1 irq", {7'd0, irq_no}, 8'h01);
    chk("R1 sqw", {7'd0, sqw_o}, 8'h00);
    rst_ni = 1'b1;
    rd(3'd0, 8'h00, 8'h78, "R1 ctrl enables");
    rd(3'd1, 8'h00, 8'hFF, "R1 flags");
    rd(3'd4, 8'h00, 8'hFF, "R1 alarm hr");

    // R3 readback
    wr(3'd0, 8'h07); rd(3'd0, 8'h07, 8'hFF, "R3 ctrl");
    wr(3'd0, 8'h7F); rd(3'd0, 8'h7F, 8'hFF, "R3 ctrl");
    // R10
    sqw_src_i = 1'b1; step(); chk("R10 sqw follows", {7'd0, sqw_o}, 8'h01);
    sqw_src_i = 1'b0; step(); chk("R10 sqw follows", {7'd0, sqw_o}, 8'h00);
    // R4
    wr(3'd0, 8'h97); rd(3'd0, 8'h87, 8'hFF, "R4 set rise clears uie");
    wr(3'd0, 8'h97); rd(3'd0, 8'h97, 8'hFF, "R4 set held keeps uie");
    wr(3'd0, 8'hFF); rd(3'd0, 8'hFF, 8'hFF, "R3 ctrl");
    // R2 / R1 reset with retained bits
    step(); rst_ni = 1'b0; step(); step(); rst_ni = 1'b1;
    rd(3'd0, 8'h87, 8'hFF, "R2 retained bits");
    sqw_src_i = 1'b1; step(); chk("R10 sqw held low", {7'd0, sqw_o}, 8'h00);
    sqw_src_i = 1'b0;

    // R5
    wr(3'd0, 8'h07);
    pulse(0); chk("R5 pf masked irq", {7'd0, irq_no}, 8'h01);
    rd(3'd1, 8'h40, 8'hFF, "R5 pf set without pie");
    wr(3'd0, 8'h47);
    pulse(0); chk("R5 pf irq", {7'd0, irq_no}, 8'h00);
    rd(3'd1, 8'hC0, 8'hFF, "R9 summary and pf");
    chk("R9 irq released", {7'd0, irq_no}, 8'h01);
    rd(3'd1, 8'h00, 8'hFF, "R9 flags cleared");
    // R11
    wr(3'd0, 8'h07); pulse(0);
    chk("R11 masked", {7'd0, irq_no}, 8'h01);
    wr(3'd0, 8'h47);
    chk("R11 enable asserts irq", {7'd0, irq_no}, 8'h00);
    rd(3'd1, 8'hC0, 8'hFF, "R11 read");

    // R6
    wr(3'd2, 8'h30); wr(3'd3, 8'h15); wr(3'd4, 8'h08);
    rd(3'd2, 8'h30, 8'hFF, "R3 alarm sec");
    rd(3'd4, 8'h08, 8'hFF, "R3 alarm hr");
    rd(3'd6, 8'h00, 8'hFF, "R3 unused addr");
    wr(3'd0, 8'h27);
    set_time(8'h30, 8'h15, 8'h08); pulse(1);
    chk("R6 alarm irq", {7'd0, irq_no}, 8'h00);
    rd(3'd1, 8'hA0, 8'hFF, "R6 alarm match");
    step(); step();
    chk("R6 no tick no irq", {7'd0, irq_no}, 8'h01);
    rd(3'd1, 8'h00, 8'hFF, "R6 no tick");
    set_time(8'h31, 8'h15, 8'h08); pulse(1); rd(3'd1, 8'h00, 8'hFF, "R6 sec mismatch");
    set_time(8'h30, 8'h16, 8'h08); pulse(1); rd(3'd1, 8'h00, 8'hFF, "R6 min mismatch");
    set_time(8'h30, 8'h15, 8'h09); pulse(1); rd(3'd1, 8'h00, 8'hFF, "R6 hr mismatch");

    // R7
    wr(3'd3, 8'hFF); wr(3'd4, 8'hC0);
    set_time(8'h30, 8'h42, 8'h17); pulse(1); rd(3'd1, 8'hA0, 8'hFF, "R7 wildcard");
    wr(3'd4, 8'h80); pulse(1); rd(3'd1, 8'h00, 8'hFF, "R7 bit7 only exact");
    wr(3'd4, 8'h40); pulse(1); rd(3'd1, 8'h00, 8'hFF, "R7 bit6 only exact");
    wr(3'd4, 8'hC0); wr(3'd2, 8'hDA);
    set_time(8'h05, 8'h42, 8'h17); pulse(1); rd(3'd1, 8'hA0, 8'hFF, "R7 all wildcard");

    // R8
    wr(3'd0, 8'h07); pulse(2);
    chk("R8 uf masked", {7'd0, irq_no}, 8'h01);
    rd(3'd1, 8'h10, 8'hFF, "R8 uf set");
    wr(3'd0, 8'h17); pulse(2);
    chk("R8 uf irq", {7'd0, irq_no}, 8'h00);
    rd(3'd1, 8'h90, 8'hFF, "R8 summary and uf");

    // R12
    wr(3'd0, 8'h07);
    rd(3'd1, 8'h00, 8'hFF, "R12 read during tick", 1'b1);
    rd(3'd1, 8'h40, 8'hFF, "R12 event kept");

    // several flags, one enabled
    pulse(0); pulse(2); wr(3'd0, 8'h17);
    rd(3'd1, 8'hD0, 8'hFF, "R9 mixed flags");

    step(); step();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule